// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Controller

This block gives every hart of a cluster two machine-level interrupt sources. The first is a software-interrupt flag. Any agent can set or clear it with a register write, which is how one hart signals another. The second is a timer interrupt. It is raised when a shared 64-bit time counter reaches a per-hart 64-bit compare value. All state is reached through a 32-bit register port. Each 64-bit register is split into a low word and a high word, and each word is written on its own.

The address map has a fixed per-hart layout. The software-interrupt words sit at offset 0x0000 with a stride of 4 bytes. The compare registers sit at offset 0x4000 with a stride of 8 bytes; the low word is at the slot address and the high word at slot + 4. The shared counter is at 0xBFF8 (low word) and 0xBFFC (high word). The map has room for 64 hart slots. Only the first `NUM_HARTS` slots are populated. The counter advances by one in each cycle where `tick_en` is high; for a 10 MHz time base, one second is 10,000,000 ticks.

The register port uses valid/ready in both directions.
- A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- Every taken request, read or write, returns exactly one response.
- `rsp_valid` and `rsp_rdata` stay unchanged until `rsp_ready` is seen high.
- While a response waits, `req_ready` is low. This back-pressure holds the requester, so at most one transaction is in flight.

Top module: `hart_irq_timer`

## Requirements
- R1: After reset, every software-interrupt flag is 0, every compare register is all ones, both interrupt vectors are 0, and `rsp_valid` is 0.
- R2: A write to offset hart*4 stores bit 0 of the write data as that hart's software-interrupt flag. `sw_irq[hart]` follows the stored flag from the cycle after the write. A read returns the flag in bit 0 and zero in bits 31:1.
- R3: The compare register of a hart is at 0x4000 + hart*8 (bits 31:0) and at 0x4000 + hart*8 + 4 (bits 63:32). A write to one half leaves the other half unchanged, and a read returns the half that was addressed.
- R4: `tm_irq[hart]` is high whenever the counter is greater than or equal to that hart's compare value (unsigned 64-bit comparison). Writing a compare value above the counter drops the line in the cycle after the write.
- R5: The counter is at 0xBFF8 (bits 31:0) and 0xBFFC (bits 63:32).
  - It advances by exactly one in each cycle with `tick_en` high, with carry into the high word, and holds its value otherwise.
  - A write to one half loads that half.
- R6: These accesses read as zero and their writes change no state:
  - any offset outside the three regions;
  - any offset that is not word aligned;
  - any slot index at or above `NUM_HARTS`.
- R7: Handshake rules:
  - every accepted request gives exactly one response, in order;
  - a write response carries zero data;
  - while `rsp_valid` is high and `rsp_ready` is low, the response and its data are held;
  - `req_ready` is low while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one tick per high cycle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (low while a response is pending) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted by the requester |
| rsp_rdata | output | 32 | Read data (zero for write responses) |
| sw_irq | output | NUM_HARTS | Software interrupt, one line per hart |
| tm_irq | output | NUM_HARTS | Timer interrupt, one line per hart |

## Verification
Corrupted internal state shows up at the ports one cycle after the write that should have set it.
- A compare half that is clobbered shows on `tm_irq` in the next cycle, or on the next read of the other half.
- A wrong decode of an unmapped slot shows as a spurious `sw_irq` or `tm_irq` right after the write.
- A counter that skips a tick or drops its carry is exposed by reading it back after a counted burst of `tick_en` cycles.
- A handshake fault appears as a missing response, an extra response, or read data that changes while the requester stalls with `rsp_ready` low.

// File: rtl/hart_irq_timer_pkg.sv
package hart_irq_timer_pkg;
  localparam int unsigned MAX_SLOTS = 64;
  localparam logic [15:0] SWI_REGION  = 16'h0000;
  localparam logic [15:0] CMP_REGION  = 16'h4000;
  localparam logic [15:0] CNT_LO_ADDR = 16'hBFF8;
  localparam logic [15:0] CNT_HI_ADDR = 16'hBFFC;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_SWI  = 2'd1,
    REG_CMP  = 2'd2,
    REG_CNT  = 2'd3
  } region_e;
endpackage

// File: rtl/hart_irq_timer_count.sv
module hart_irq_timer_count (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wr_data,
  output logic [63:0] count
);
  logic [63:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (we_lo) begin
      cnt_q <= {cnt_q[63:32], wr_data};
    end else if (we_hi) begin
      cnt_q <= {wr_data, cnt_q[31:0]};
    end else if (tick_en) begin
      cnt_q <= cnt_q + 64'd1;
    end
  end

  assign count = cnt_q;

  // R5: one tick per enabled cycle when no load is in progress
  p_tick_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !we_lo && !we_hi) |=> (count == $past(count) + 64'd1));

  // R5: without tick or load, the counter holds
  p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !we_lo && !we_hi) |=> $stable(count));
endmodule

// File: rtl/hart_irq_timer_slot.sv
module hart_irq_timer_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swi_we,
  input  logic        cmp_we_lo,
  input  logic        cmp_we_hi,
  input  logic [31:0] wr_data,
  input  logic [63:0] count,
  output logic        swi_flag,
  output logic [63:0] cmp_val,
  output logic        tm_line
);
  logic        swi_q;
  logic [63:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_q <= 1'b0;
    end else if (swi_we) begin
      swi_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else begin
      if (cmp_we_lo) cmp_q[31:0]  <= wr_data;
      if (cmp_we_hi) cmp_q[63:32] <= wr_data;
    end
  end

  assign swi_flag = swi_q;
  assign cmp_val  = cmp_q;
  assign tm_line  = (count >= cmp_q);

  // R2: the flag changes only through its own write strobe
  p_swi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !swi_we |=> $stable(swi_flag));

  // R3: writing the low half never touches the high half
  p_cmp_hi_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_we_hi |=> (cmp_val[63:32] == $past(cmp_val[63:32])));

  // R3: writing the high half never touches the low half
  p_cmp_lo_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_we_lo |=> (cmp_val[31:0] == $past(cmp_val[31:0])));
endmodule

// File: rtl/hart_irq_timer_front.sv
module hart_irq_timer_front
  import hart_irq_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [15:0]                req_addr,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_rdata,
  input  logic [NUM_HARTS-1:0]       swi_flags,
  input  logic [NUM_HARTS-1:0][63:0] cmp_vals,
  input  logic [63:0]                count,
  output logic [NUM_HARTS-1:0]       swi_we,
  output logic [NUM_HARTS-1:0]       cmp_we_lo,
  output logic [NUM_HARTS-1:0]       cmp_we_hi,
  output logic                       cnt_we_lo,
  output logic                       cnt_we_hi,
  output logic [31:0]                wr_data
);
  localparam int unsigned SLOT_W = $clog2(MAX_SLOTS);

  logic              pend_q;
  logic [31:0]       rdata_q;
  logic              fire;
  region_e           region;
  logic [SLOT_W-1:0] slot;
  logic              upper;
  logic              slot_ok;
  logic [31:0]       rd_mux;

  assign req_ready = !pend_q;
  assign fire      = req_valid && req_ready;
  assign wr_data   = req_wdata;

  // Address decode: region, slot index and upper/lower half
  always_comb begin
    region = REG_NONE;
    slot   = '0;
    upper  = 1'b0;
    if (req_addr[1:0] == 2'b00) begin
      if (req_addr[15:8] == SWI_REGION[15:8]) begin
        region = REG_SWI;
        slot   = req_addr[7:2];
      end else if (req_addr[15:9] == CMP_REGION[15:9]) begin
        region = REG_CMP;
        slot   = req_addr[8:3];
        upper  = req_addr[2];
      end else if (req_addr == CNT_LO_ADDR || req_addr == CNT_HI_ADDR) begin
        region = REG_CNT;
        upper  = req_addr[2];
      end
    end
  end

  assign slot_ok = (int'(slot) < int'(NUM_HARTS));

  // Per-hart write strobes, only for populated slots
  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_strobe
      logic hit;
      assign hit          = fire && req_write && (int'(slot) == h);
      assign swi_we[h]    = hit && (region == REG_SWI);
      assign cmp_we_lo[h] = hit && (region == REG_CMP) && !upper;
      assign cmp_we_hi[h] = hit && (region == REG_CMP) &&  upper;
    end
  endgenerate

  assign cnt_we_lo = fire && req_write && (region == REG_CNT) && !upper;
  assign cnt_we_hi = fire && req_write && (region == REG_CNT) &&  upper;

  // Read data selection
  always_comb begin
    rd_mux = '0;
    unique case (region)
      REG_SWI: begin
        for (int h = 0; h < NUM_HARTS; h++) begin
          if (int'(slot) == h) rd_mux = {31'd0, swi_flags[h]};
        end
      end
      REG_CMP: begin
        for (int h = 0; h < NUM_HARTS; h++) begin
          if (int'(slot) == h) rd_mux = upper ? cmp_vals[h][63:32] : cmp_vals[h][31:0];
        end
      end
      REG_CNT: rd_mux = upper ? count[63:32] : count[31:0];
      default: rd_mux = '0;
    endcase
    if (region != REG_CNT && !slot_ok) rd_mux = '0;
  end

  // Single-entry response holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      rdata_q <= '0;
    end else if (fire) begin
      pend_q  <= 1'b1;
      rdata_q <= req_write ? 32'd0 : rd_mux;
    end else if (pend_q && rsp_ready) begin
      pend_q  <= 1'b0;
    end
  end

  assign rsp_valid = pend_q;
  assign rsp_rdata = rdata_q;

  // R7: a stalled response keeps both its valid and its data
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R7: an accepted request yields a response in the next cycle
  p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R7: write responses carry zero data
  p_wr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_rdata == 32'd0));

  // R6: the gap above the counter words reads as zero
  p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr >= 16'hC000) |=> (rsp_rdata == 32'd0));
endmodule

// File: rtl/hart_irq_timer.sv
module hart_irq_timer #(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] sw_irq,
  output logic [NUM_HARTS-1:0] tm_irq
);
  logic [NUM_HARTS-1:0]       swi_flags;
  logic [NUM_HARTS-1:0][63:0] cmp_vals;
  logic [NUM_HARTS-1:0]       swi_we;
  logic [NUM_HARTS-1:0]       cmp_we_lo;
  logic [NUM_HARTS-1:0]       cmp_we_hi;
  logic                       cnt_we_lo;
  logic                       cnt_we_hi;
  logic [31:0]                wr_data;
  logic [63:0]                count;

  hart_irq_timer_front #(.NUM_HARTS(NUM_HARTS)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .swi_flags (swi_flags),
    .cmp_vals  (cmp_vals),
    .count     (count),
    .swi_we    (swi_we),
    .cmp_we_lo (cmp_we_lo),
    .cmp_we_hi (cmp_we_hi),
    .cnt_we_lo (cnt_we_lo),
    .cnt_we_hi (cnt_we_hi),
    .wr_data   (wr_data)
  );

  hart_irq_timer_count u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .we_lo   (cnt_we_lo),
    .we_hi   (cnt_we_hi),
    .wr_data (wr_data),
    .count   (count)
  );

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      hart_irq_timer_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .swi_we    (swi_we[h]),
        .cmp_we_lo (cmp_we_lo[h]),
        .cmp_we_hi (cmp_we_hi[h]),
        .wr_data   (wr_data),
        .count     (count),
        .swi_flag  (swi_flags[h]),
        .cmp_val   (cmp_vals[h]),
        .tm_line   (tm_irq[h])
      );
    end
  endgenerate

  assign sw_irq = swi_flags;

  initial begin
    p_param_range_r6: assert (NUM_HARTS >= 1 && NUM_HARTS <= 64)
      else $error("NUM_HARTS outside 1..64");
  end

  // R7: no new request is taken while a response waits
  p_one_in_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/hart_irq_timer_tb.sv
module hart_irq_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [15:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [31:0]   rsp_rdata;
  logic [N-1:0]  sw_irq;
  logic [N-1:0]  tm_irq;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_irq_timer #(.NUM_HARTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .sw_irq(sw_irq), .tm_irq(tm_irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one transfer, expected response pushed to the scoreboard
  task automatic xfer(bit wr, logic [15:0] addr, logic [31:0] data,
                      logic [31:0] exp, string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    exp_q.push_back(wr ? 32'd0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr32(logic [15:0] a, logic [31:0] d, string tag);
    xfer(1'b1, a, d, 32'd0, tag);
  endtask

  task automatic rd32(logic [15:0] a, logic [31:0] e, string tag);
    xfer(1'b0, a, 32'd0, e, tag);
  endtask

  task automatic tick(int k);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // Monitor: stalls responses on a fixed pattern, compares on handshake
  always @(negedge clk) begin
    cyc++;
    rsp_ready = (cyc % 3) != 2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_vec++;
        n_bad++;
        $display("FAIL R7 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), {32'd0, rsp_rdata}, {32'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sw_irq", sw_irq, '0);
    chk("R1 tm_irq", tm_irq, '0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rd32(16'h4000, 32'hFFFF_FFFF, "R1 cmp0 lo");
    rd32(16'h401C, 32'hFFFF_FFFF, "R1 cmp3 hi");
    rd32(16'h0008, 32'd0, "R1 swi2");

    // R2 software interrupts
    wr32(16'h0008, 32'd1, "R2 wr");
    chk("R2 set hart2", sw_irq, 4'b0100);
    wr32(16'h0000, 32'hFFFF_FFFE, "R2 wr");
    chk("R2 bit0 only", sw_irq, 4'b0100);
    wr32(16'h0000, 32'd3, "R2 wr");
    chk("R2 set hart0", sw_irq, 4'b0101);
    rd32(16'h0000, 32'd1, "R2 read bit0");
    wr32(16'h0008, 32'd0, "R2 wr");
    chk("R2 clear hart2", sw_irq, 4'b0001);

    // R6 unmapped and unpopulated
    wr32(16'h0010, 32'd1, "R6 wr");
    chk("R6 slot4 swi ignored", sw_irq, 4'b0001);
    rd32(16'h0010, 32'd0, "R6 slot4 swi");
    wr32(16'h4020, 32'd0, "R6 wr");
    chk("R6 slot4 cmp ignored", tm_irq, '0);
    rd32(16'h4020, 32'd0, "R6 slot4 cmp");
    rd32(16'h8000, 32'd0, "R6 gap");
    rd32(16'hBFF4, 32'd0, "R6 below counter");
    wr32(16'h0002, 32'd0, "R6 wr");
    chk("R6 misaligned ignored", sw_irq, 4'b0001);

    // R3 split compare access
    wr32(16'h4018, 32'h1234_5678, "R3 wr");
    rd32(16'h4018, 32'h1234_5678, "R3 cmp3 lo");
    rd32(16'h401C, 32'hFFFF_FFFF, "R3 cmp3 hi kept");
    wr32(16'h401C, 32'h0000_000A, "R3 wr");
    rd32(16'h401C, 32'h0000_000A, "R3 cmp3 hi");
    rd32(16'h4018, 32'h1234_5678, "R3 cmp3 lo kept");

    // R5 counter load and tick
    wr32(16'hBFF8, 32'h10, "R5 wr");
    wr32(16'hBFFC, 32'h0, "R5 wr");
    rd32(16'hBFF8, 32'h10, "R5 load lo");
    tick(4);
    rd32(16'hBFF8, 32'h14, "R5 four ticks");

    // R4 level compare
    wr32(16'h4008, 32'h20, "R4 wr");
    chk("R4 hi still ones", tm_irq, '0);
    wr32(16'h400C, 32'h0, "R4 wr");
    chk("R4 future compare", tm_irq, '0);
    tick(12);
    chk("R4 reached", tm_irq, 4'b0010);
    wr32(16'h400C, 32'h1, "R4 wr");
    chk("R4 moved to future drops", tm_irq, 4'b0000);
    wr32(16'h400C, 32'h0, "R4 wr");
    chk("R4 back in past", tm_irq, 4'b0010);
    wr32(16'h4008, 32'h21, "R4 wr");
    chk("R4 one ahead", tm_irq, 4'b0000);
    tick(1);
    chk("R4 equal asserts", tm_irq, 4'b0010);

    // R5 carry into high word
    wr32(16'hBFF8, 32'hFFFF_FFFE, "R5 wr");
    wr32(16'hBFFC, 32'h0, "R5 wr");
    tick(3);
    rd32(16'hBFF8, 32'h1, "R5 carry lo");
    rd32(16'hBFFC, 32'h1, "R5 carry hi");
    chk("R4 after carry", tm_irq, 4'b0010);

    repeat (10) @(negedge clk);
    chk("R7 all responses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule